// File: doc/BRIEF.md
# Grouped Interrupt Priority Resolver

This block holds the state of a small set of interrupt lines and decides which of them the processor core should service next. Each line carries a 4-bit priority, an enable, a pending flag and an active flag. The winner is the enabled, pending line with the numerically smallest priority value. A full tie goes to the lowest line number.

A run-time grouping setting chooses how many of the upper priority bits form the preemption field. The remaining lower bits are the subpriority. The preemption field alone decides whether the winner may interrupt the handler now running. The full 4-bit value still orders the pending lines.

The core acknowledges a winner to enter its handler and signals handler exit to leave it. Software reaches the configuration and status through a simple register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, every priority, enable, pending and active bit and the grouping value read as 0. `winValid`, `preemptReq` and `runValid` are 0.
- R2: A priority register (address 8+i for line i) reads back the 4-bit value last written to it, whatever the grouping setting is.
- R3: A write to address 0 with a value from 0 to 4 sets the number of preemption bits. A write of 5 or more is ignored, and the old value reads back.
- R4: A write to address 2 sets every pending bit whose data bit is 1. A write to address 3 clears every such pending bit. A read of address 2 or 3 returns the pending vector.
- R5: `winLine` names the enabled, pending line with the lowest priority value, and a tie goes to the lowest line number. A disabled line never wins. Address 1 holds the enable vector. `winValid` is 1 exactly when at least one line is both enabled and pending.
- R6: `preemptReq` is 1 when a winner exists and either no line is active or the winner's preemption field (the top g priority bits, where g is the grouping value) is strictly below that of the running line. Equal fields never nest.
- R7: With grouping 0, `preemptReq` stays 0 whenever any line is active.
- R8: A cycle with `ackTake` high and `preemptReq` high clears the winner's pending bit and sets its active bit on that edge. `ackTake` without `preemptReq` changes nothing.
- R9: The running line is the active line with the lowest priority value, and a tie goes to the lowest line number. `exitHandler` clears the running line's active bit, so the running line falls back to the next active line, or to none.
- R10: A change of grouping updates `preemptReq` on the next cycle. It leaves the pending, active and priority state untouched.
- R11: A read of address 4 returns the active vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| ackTake | input | 1 | Core takes the current winner |
| exitHandler | input | 1 | Core leaves the running handler |
| winValid | output | 1 | A line is eligible |
| winLine | output | 3 | Winning line number |
| preemptReq | output | 1 | Winner may be taken now |
| runValid | output | 1 | Some handler is active |
| runLine | output | 3 | Running line number |

## Verification
The bench targets ties on the full priority value and a pending line that is disabled. A design that broke ties toward the higher line number, or that ignored the enable bit, would name the wrong `winLine`. It also sweeps the grouping value while the state stays fixed. A design that compared full priorities for nesting, or that let grouping 0 nest, would raise `preemptReq` in the wrong settings. Acknowledges sent without `preemptReq`, and nested exits, show whether an ignored acknowledge corrupts the state. They also show whether exit retires the wrong active bit.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned OFF_GROUP    = 0;
  localparam int unsigned OFF_ENABLE   = 1;
  localparam int unsigned OFF_PEND_SET = 2;
  localparam int unsigned OFF_PEND_CLR = 3;
  localparam int unsigned OFF_ACTIVE   = 4;

  typedef struct packed {
    logic grpWe;
    logic enWe;
    logic pendSetWe;
    logic pendClrWe;
    logic prioWe;
    logic ackDo;
    logic exitDo;
  } strobes_t;
endpackage

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 4,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 found,
  output logic [LW-1:0]        line,
  output logic [PW-1:0]        bestPrio
);
  always_comb begin
    found    = 1'b0;
    line     = '0;
    bestPrio = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || prio[i] < bestPrio)) begin
        found    = 1'b1;
        line     = LW'(i);
        bestPrio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 4,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic          ackTake,
  input  logic          exitHandler,
  input  logic          preemptReq,
  input  logic          runValid,
  output strobes_t      strobes
);
  localparam int unsigned OW = AW - 1;

  logic          isPrio;
  logic [OW-1:0] offset;

  assign isPrio = regAddr[AW-1];
  assign offset = regAddr[OW-1:0];

  always_comb begin
    strobes           = '0;
    strobes.prioWe    = regWe && isPrio && (int'(offset) < N);
    strobes.grpWe     = regWe && !isPrio && (offset == OW'(OFF_GROUP))
                        && (int'(regWdata) <= PW);
    strobes.enWe      = regWe && !isPrio && (offset == OW'(OFF_ENABLE));
    strobes.pendSetWe = regWe && !isPrio && (offset == OW'(OFF_PEND_SET));
    strobes.pendClrWe = regWe && !isPrio && (offset == OW'(OFF_PEND_CLR));
    strobes.ackDo     = ackTake && preemptReq;
    strobes.exitDo    = exitHandler && runValid;
  end
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 4,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(N),
  localparam int unsigned GW = $clog2(PW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strobes,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          winValid,
  output logic [LW-1:0] winLine,
  output logic          preemptReq,
  output logic          runValid,
  output logic [LW-1:0] runLine,
  output logic [N-1:0]  pendVec,
  output logic [N-1:0]  enVec,
  output logic [N-1:0]  actVec,
  output logic [GW-1:0] grpVal
);
  localparam int unsigned OW = AW - 1;

  logic [N-1:0][PW-1:0] prioArr;
  logic [N-1:0]         pendReg, enReg, actReg;
  logic [GW-1:0]        grpReg;
  logic [PW-1:0]        winPrio, runPrio;
  logic [N-1:0]         ackMask, exitMask;
  logic [OW-1:0]        offset;

  assign offset = regAddr[OW-1:0];

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioArr[i] <= '0;
      end else if (strobes.prioWe && offset == OW'(i)) begin
        prioArr[i] <= regWdata[PW-1:0];
      end
    end
    assign ackMask[i]  = strobes.ackDo  && (winLine == LW'(i));
    assign exitMask[i] = strobes.exitDo && (runLine == LW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      enReg   <= '0;
      actReg  <= '0;
      grpReg  <= '0;
    end else begin
      if (strobes.grpWe) grpReg <= regWdata[GW-1:0];
      if (strobes.enWe)  enReg  <= regWdata[N-1:0];
      pendReg <= (pendReg | (strobes.pendSetWe ? regWdata[N-1:0] : '0))
                 & ~(strobes.pendClrWe ? regWdata[N-1:0] : '0)
                 & ~ackMask;
      actReg  <= (actReg | ackMask) & ~exitMask;
    end
  end

  irq_arb_pick #(.N(N), .PW(PW)) u_pickWin (
    .req(pendReg & enReg), .prio(prioArr),
    .found(winValid), .line(winLine), .bestPrio(winPrio)
  );

  irq_arb_pick #(.N(N), .PW(PW)) u_pickRun (
    .req(actReg), .prio(prioArr),
    .found(runValid), .line(runLine), .bestPrio(runPrio)
  );

  function automatic logic [PW-1:0] preField(input logic [PW-1:0] p,
                                             input logic [GW-1:0] g);
    return p >> (PW - int'(g));
  endfunction

  assign preemptReq = winValid &&
                      (!runValid || preField(winPrio, grpReg) < preField(runPrio, grpReg));

  always_comb begin
    regRdata = '0;
    if (regAddr[AW-1]) begin
      if (int'(offset) < N) regRdata[PW-1:0] = prioArr[offset[LW-1:0]];
    end else begin
      case (int'(offset))
        OFF_GROUP:                  regRdata[GW-1:0] = grpReg;
        OFF_ENABLE:                 regRdata[N-1:0]  = enReg;
        OFF_PEND_SET, OFF_PEND_CLR: regRdata[N-1:0]  = pendReg;
        OFF_ACTIVE:                 regRdata[N-1:0]  = actReg;
        default:                    regRdata         = '0;
      endcase
    end
  end

  assign pendVec = pendReg;
  assign enVec   = enReg;
  assign actVec  = actReg;
  assign grpVal  = grpReg;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PRIO_W    = 4,
  localparam int unsigned LW = $clog2(NUM_LINES),
  localparam int unsigned AW = LW + 1,
  localparam int unsigned DW = (NUM_LINES > PRIO_W) ? NUM_LINES : PRIO_W,
  localparam int unsigned GW = $clog2(PRIO_W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          ackTake,
  input  logic          exitHandler,
  output logic          winValid,
  output logic [LW-1:0] winLine,
  output logic          preemptReq,
  output logic          runValid,
  output logic [LW-1:0] runLine
);
  strobes_t         strobes;
  logic [NUM_LINES-1:0] pendVec, enVec, actVec;
  logic [GW-1:0]    grpVal;

  irq_arb_control #(.N(NUM_LINES), .PW(PRIO_W), .AW(AW), .DW(DW)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .ackTake(ackTake), .exitHandler(exitHandler),
    .preemptReq(preemptReq), .runValid(runValid), .strobes(strobes)
  );

  irq_arb_datapath #(.N(NUM_LINES), .PW(PRIO_W), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .winValid(winValid), .winLine(winLine), .preemptReq(preemptReq),
    .runValid(runValid), .runLine(runLine),
    .pendVec(pendVec), .enVec(enVec), .actVec(actVec), .grpVal(grpVal)
  );
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 4,
  localparam int unsigned LW = $clog2(N),
  localparam int unsigned GW = $clog2(PW + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWe,
  input logic          ackTake,
  input logic          exitHandler,
  input logic          winValid,
  input logic [LW-1:0] winLine,
  input logic          preemptReq,
  input logic          runValid,
  input logic [LW-1:0] runLine,
  input logic [N-1:0]  pendVec,
  input logic [N-1:0]  enVec,
  input logic [N-1:0]  actVec,
  input logic [GW-1:0] grpVal
);
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (pendVec[winLine] && enVec[winLine]));                 // R5
  AST_WIN_NOT_MISSED: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendVec & enVec)) |-> winValid);                                 // R5
  AST_PREEMPT_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rstN)
    preemptReq |-> winValid);                                           // R6
  AST_GRP0_NO_NEST: assert property (@(posedge clk) disable iff (!rstN)
    (grpVal == '0 && runValid) |-> !preemptReq);                        // R7
  AST_GRP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(grpVal) <= PW);                                                // R3
  AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (ackTake && preemptReq && !regWe && !exitHandler)
      |=> (!pendVec[$past(winLine)] && actVec[$past(winLine)]));        // R8
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (exitHandler && runValid && !ackTake) |=> !actVec[$past(runLine)]); // R9
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N(NUM_LINES), .PW(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .ackTake(ackTake),
  .exitHandler(exitHandler), .winValid(winValid), .winLine(winLine),
  .preemptReq(preemptReq), .runValid(runValid), .runLine(runLine),
  .pendVec(pendVec), .enVec(enVec), .actVec(actVec), .grpVal(grpVal)
);

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       ackTake = 1'b0;
  logic       exitHandler = 1'b0;
  logic       winValid, preemptReq, runValid;
  logic [2:0] winLine, runLine;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ackTake(ackTake),
    .exitHandler(exitHandler), .winValid(winValid), .winLine(winLine),
    .preemptReq(preemptReq), .runValid(runValid), .runLine(runLine)
  );

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] data;
    logic       expValid;
    logic [2:0] expLine;
    logic       expPre;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TABLE [NVEC] = '{
    '{4'd11, 8'd5,    1'b0, 3'd0, 1'b0, 4'd5}, // R5 line3 prio 5, nothing pending
    '{4'd13, 8'd5,    1'b0, 3'd0, 1'b0, 4'd5}, // R5 line5 prio 5
    '{4'd14, 8'd2,    1'b0, 3'd0, 1'b0, 4'd5}, // R5 line6 prio 2
    '{4'd1,  8'h68,   1'b0, 3'd0, 1'b0, 4'd5}, // R5 enable lines 3,5,6
    '{4'd2,  8'h28,   1'b1, 3'd3, 1'b1, 4'd5}, // R5 tie on 5 -> lowest line
    '{4'd2,  8'h40,   1'b1, 3'd6, 1'b1, 4'd5}, // R5 lower value wins
    '{4'd2,  8'h01,   1'b1, 3'd6, 1'b1, 4'd5}, // R5 disabled line0 ignored
    '{4'd3,  8'h40,   1'b1, 3'd3, 1'b1, 4'd4}, // R4 clear line6 pending
    '{4'd1,  8'h69,   1'b1, 3'd0, 1'b1, 4'd5}, // R5 enabling line0 makes it win
    '{4'd1,  8'h68,   1'b1, 3'd3, 1'b1, 4'd5}  // R5 disabling it again
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    regAddr = a;
    #1;
    check(tag, int'(regRdata), exp);
  endtask

  task automatic pulseAck();
    @(negedge clk); ackTake = 1'b1;
    @(negedge clk); ackTake = 1'b0;
  endtask

  task automatic pulseExit();
    @(negedge clk); exitHandler = 1'b1;
    @(negedge clk); exitHandler = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 winValid", int'(winValid), 0);
    check("R1 preemptReq", int'(preemptReq), 0);
    check("R1 runValid", int'(runValid), 0);
    rd(4'd0, 0, "R1 group");
    rd(4'd1, 0, "R1 enable");
    rd(4'd2, 0, "R1 pending");
    rd(4'd4, 0, "R11 active after reset");
    rd(4'd13, 0, "R1 prio line5");

    for (int k = 0; k < NVEC; k++) begin
      wr(TABLE[k].addr, TABLE[k].data);
      check($sformatf("R%0d vec%0d winValid", TABLE[k].req, k), int'(winValid), int'(TABLE[k].expValid));
      if (TABLE[k].expValid)
        check($sformatf("R%0d vec%0d winLine", TABLE[k].req, k), int'(winLine), int'(TABLE[k].expLine));
      check($sformatf("R6 vec%0d preemptReq idle", k), int'(preemptReq), int'(TABLE[k].expPre));
    end
    rd(4'd2, 8'h29, "R4 pending readback");
    rd(4'd3, 8'h29, "R4 pending readback at clear address");

    // grouping 2: line3 prio 0101 field 01
    wr(4'd0, 8'd2);
    check("R6 idle winner may be taken", int'(preemptReq), 1);
    pulseAck();
    rd(4'd4, 8'h08, "R11 active after ack");
    rd(4'd2, 8'h21, "R8 pending cleared by ack");
    check("R9 runValid", int'(runValid), 1);
    check("R9 runLine", int'(runLine), 3);
    check("R5 next winner", int'(winLine), 5);
    check("R6 equal field never nests", int'(preemptReq), 0);
    pulseAck();
    rd(4'd4, 8'h08, "R8 ack without preemptReq ignored (active)");
    rd(4'd2, 8'h21, "R8 ack without preemptReq ignored (pending)");

    wr(4'd13, 8'd3);
    check("R6 lower field nests", int'(preemptReq), 1);
    wr(4'd0, 8'd0);
    check("R7 grouping 0 blocks nesting", int'(preemptReq), 0);
    rd(4'd2, 8'h21, "R10 pending untouched");
    rd(4'd4, 8'h08, "R10 active untouched");
    rd(4'd13, 3, "R10 prio untouched");
    wr(4'd0, 8'd4);
    check("R10 grouping 4 nests", int'(preemptReq), 1);
    wr(4'd0, 8'd1);
    check("R10 grouping 1 fields equal", int'(preemptReq), 0);
    wr(4'd0, 8'd7);
    rd(4'd0, 1, "R3 illegal grouping ignored");
    check("R3 preemptReq unchanged", int'(preemptReq), 0);
    wr(4'd0, 8'd2);
    rd(4'd0, 2, "R3 grouping readback");
    check("R10 grouping 2 nests", int'(preemptReq), 1);

    pulseAck();
    rd(4'd4, 8'h28, "R8 nested ack sets active");
    check("R5 no eligible line left", int'(winValid), 0);
    check("R6 no winner no request", int'(preemptReq), 0);
    check("R9 nested runLine", int'(runLine), 5);
    pulseExit();
    check("R9 exit falls back", int'(runLine), 3);
    rd(4'd4, 8'h08, "R9 active after first exit");
    pulseExit();
    check("R9 exit to idle", int'(runValid), 0);
    rd(4'd4, 0, "R11 active empty");
    rd(4'd13, 3, "R2 prio line5 readback");
    rd(4'd11, 5, "R2 prio line3 readback");
    rd(4'd14, 2, "R2 prio line6 readback");

    finishRun();
  end
endmodule